// File: doc/BRIEF.md
# Scratchpad Memory Command Engine

This block is the byte-level memory command handler of a single-wire EEPROM slave. It sits behind a bit-timing front end. Bytes the front end decodes arrive on a receive stream, and bytes the master reads leave on a transmit stream. Once the address-selection layer raises `granted`, the engine takes one command byte. For a scratchpad or memory access it then takes a one-byte start address. After that it streams data into or out of a 32-byte scratchpad, with no length limit. A `bus_reset` strobe from the front end is the only thing that ends a stream.

The scratchpad is a staging buffer. The master can write bytes into it and read them back to check them. A commit command then copies the whole scratchpad into a separate 32-byte data memory, which can be rewritten any number of times and read back with its own command. Command codes: 0Fh writes the scratchpad, AAh reads the scratchpad, 55h commits the scratchpad to memory, and F0h reads the memory.

Back-pressure rules. The receive stream is never stalled: `rx_ready` is always high, and every cycle with `rx_valid` high delivers one byte. Bytes that arrive in a state where they mean nothing are dropped. The transmit stream is valid/ready. While a read stream is active, `tx_valid` stays high. `tx_data` holds still until a cycle in which `tx_ready` is high, and each such handshake moves to the next byte.

Top module: `scratch_cmd_engine`

## Requirements
- R1: After `rst_n` is released, `tx_valid` is 0 and `rx_ready` is 1. All scratchpad bytes and all memory bytes read back as 00h.
- R2: With `granted` high in the command-wait state, byte 0Fh starts a scratchpad write. The next byte is the start address. Each byte after that is stored at the current address, and the address then advances by one.
- R3: Byte AAh starts a scratchpad read. The next byte is the start address. From the following cycle, `tx_valid` is 1 and `tx_data` shows the byte at the current address. Each handshake (`tx_valid` and `tx_ready` both high) advances the address by one.
- R4: Only address bits [4:0] select a byte. For example, address E5h selects byte 05h.
- R5: After the byte at address 1Fh is written or read, the address wraps to 00h and the stream continues.
- R6: A stream never ends by itself. A pulse on `bus_reset` returns the engine to command wait from any state, takes effect in the same cycle, and overrides any byte delivered in that cycle.
- R7: Any command byte other than 0Fh, AAh, 55h or F0h sends the engine to a halt state. There it writes nothing and keeps `tx_valid` at 0 until the next `bus_reset`.
- R8: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` and the address stay unchanged.
- R9: Byte 55h copies all 32 scratchpad bytes into the data memory in one cycle. The engine then halts as in R7. Later scratchpad writes do not change the memory.
- R10: Byte F0h starts a memory read. It works like R3 and wraps like R5, but reads the data memory.
- R11: In command wait, bytes that arrive while `granted` is 0 are ignored.
- R12: Scratchpad contents are kept across `bus_reset`, so written data can be read back and verified before it is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_reset | input | 1 | One-cycle strobe from the front end: a line reset was seen |
| granted | input | 1 | Address layer has selected this slave |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Always 1: the engine accepts every byte |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Read byte available |
| tx_ready | input | 1 | Front end takes the byte this cycle |
| tx_data | output | 8 | Byte to send |

## Verification
Writes and reads are tried at a low start address, at an address with its top bits set, and at a start near 1Fh. These cases tell correct sequential indexing apart from truncation faults and from a wrap that fails or stops. A read stream longer than two full pages checks that the stream does not end by itself. Read stalls of several cycles check that the byte is held and that the address advances only on a handshake. Further cases send an unknown command, send bytes while not granted, and raise `bus_reset` in the same cycle as a data byte. Each is followed by a readback at the ports, which shows whether a stray write got through. A commit followed by a scratchpad rewrite shows whether the memory truly holds its own copy.

// File: rtl/scpad_pkg.sv
package scpad_pkg;
  typedef enum logic [2:0] {
    ST_CMD, ST_WADDR, ST_WDATA, ST_RADDR, ST_RDATA, ST_MADDR, ST_MDATA, ST_HALT
  } eng_state_t;

  localparam logic [7:0] OP_SP_WRITE = 8'h0F;
  localparam logic [7:0] OP_SP_READ  = 8'hAA;
  localparam logic [7:0] OP_COMMIT   = 8'h55;
  localparam logic [7:0] OP_MEM_READ = 8'hF0;
endpackage

// File: rtl/scpad_fsm.sv
module scpad_fsm
  import scpad_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset,
  input  logic       granted,
  input  logic       rx_fire,
  input  logic [7:0] rx_byte,
  input  logic       tx_fire,
  output eng_state_t state,
  output logic       load_addr,
  output logic       step_addr,
  output logic       sp_we,
  output logic       commit
);
  eng_state_t nxt;
  logic       cmd_take;

  assign cmd_take  = rx_fire && granted && (state == ST_CMD) && !bus_reset;
  assign load_addr = rx_fire && !bus_reset &&
                     (state == ST_WADDR || state == ST_RADDR || state == ST_MADDR);
  assign sp_we     = rx_fire && !bus_reset && (state == ST_WDATA);
  assign step_addr = sp_we || (tx_fire && !bus_reset);
  assign commit    = cmd_take && (rx_byte == OP_COMMIT);

  always_comb begin
    nxt = state;
    if (bus_reset) begin
      nxt = ST_CMD;
    end else begin
      case (state)
        ST_CMD: begin
          if (rx_fire && granted) begin
            case (rx_byte)
              OP_SP_WRITE: nxt = ST_WADDR;
              OP_SP_READ:  nxt = ST_RADDR;
              OP_MEM_READ: nxt = ST_MADDR;
              default:     nxt = ST_HALT;
            endcase
          end
        end
        ST_WADDR: if (rx_fire) nxt = ST_WDATA;
        ST_RADDR: if (rx_fire) nxt = ST_RDATA;
        ST_MADDR: if (rx_fire) nxt = ST_MDATA;
        default:  nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_CMD;
    else        state <= nxt;
  end
endmodule

// File: rtl/scpad_addr.sv
module scpad_addr #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (load)    addr <= load_val;
    else if (step)    addr <= (addr == LAST) ? '0 : addr + 1'b1;
  end
endmodule

// File: rtl/scpad_bank.sv
module scpad_bank #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [DW-1:0]       wdata,
  input  logic                bulk_load,
  input  logic [DEPTH*DW-1:0] bulk_in,
  output logic [DEPTH*DW-1:0] contents
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (bulk_load)                  q <= bulk_in[i*DW +: DW];
      else if (we && waddr == AW'(i))      q <= wdata;
    end
    assign contents[i*DW +: DW] = q;
  end
endmodule

// File: rtl/scratch_cmd_engine.sv
module scratch_cmd_engine
  import scpad_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int DW   = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_reset,
  input  logic          granted,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_byte,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data
);
  eng_state_t          state;
  logic                load_addr, step_addr, sp_we, commit, tx_fire;
  logic [AW-1:0]       addr;
  logic [DEPTH*DW-1:0] sp_flat, mem_flat;

  assign rx_ready = 1'b1;
  assign tx_valid = (state == ST_RDATA) || (state == ST_MDATA);
  assign tx_fire  = tx_valid && tx_ready;

  scpad_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .granted(granted),
    .rx_fire(rx_valid), .rx_byte(rx_byte), .tx_fire(tx_fire),
    .state(state), .load_addr(load_addr), .step_addr(step_addr),
    .sp_we(sp_we), .commit(commit)
  );

  scpad_addr #(.DEPTH(DEPTH)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load_addr), .load_val(rx_byte[AW-1:0]),
    .step(step_addr), .addr(addr)
  );

  scpad_bank #(.DEPTH(DEPTH), .DW(DW)) u_scratch (
    .clk(clk), .rst_n(rst_n), .we(sp_we), .waddr(addr), .wdata(rx_byte),
    .bulk_load(1'b0), .bulk_in('0), .contents(sp_flat)
  );

  scpad_bank #(.DEPTH(DEPTH), .DW(DW)) u_memory (
    .clk(clk), .rst_n(rst_n), .we(1'b0), .waddr('0), .wdata('0),
    .bulk_load(commit), .bulk_in(sp_flat), .contents(mem_flat)
  );

  assign tx_data = (state == ST_MDATA) ? mem_flat[int'(addr)*DW +: DW]
                                       : sp_flat[int'(addr)*DW +: DW];
endmodule

// File: rtl/scpad_checker.sv
module scpad_checker
  import scpad_pkg::*;
#(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_reset,
  input logic          granted,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input eng_state_t    state,
  input logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = '1;

  // R3: each accepted read byte moves the address forward by one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !bus_reset && addr != LAST) |=> (addr == $past(addr) + 1'b1));

  // R5: the last address wraps to zero
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !bus_reset && addr == LAST) |=> (addr == '0));

  // R8: a stalled byte is held
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !bus_reset) |=> (tx_valid && $stable(tx_data) && $stable(addr)));

  // R6: a line reset always lands in command wait
  p_busreset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (state == ST_CMD && !tx_valid));

  // R7: halt persists until a line reset
  p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && !bus_reset) |=> (state == ST_HALT && !tx_valid));

  // R11: without grant, command wait is not left
  p_nogrant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CMD && !granted && !bus_reset) |=> (state == ST_CMD));
endmodule

bind scratch_cmd_engine scpad_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .granted(granted),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .state(state), .addr(addr)
);

// File: tb/sim_scratch_cmd_engine.sv
`timescale 1ns/1ps
module sim_scratch_cmd_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_reset = 1'b0;
  logic       granted = 1'b0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] rx_byte = 8'h00;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic [7:0] tx_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  logic [7:0] exp_sp  [32];
  logic [7:0] exp_mem [32];

  always #10 clk = ~clk;

  scratch_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .granted(granted),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic line_reset();
    @(negedge clk);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
  endtask

  task automatic take(input logic [7:0] expv, input string req);
    @(negedge clk);
    chk(tx_valid === 1'b1, req, int'(tx_valid), 1);
    chk(tx_data === expv, req, int'(tx_data), int'(expv));
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic sp_write(input logic [7:0] a, input int n, input logic [7:0] seed);
    line_reset();
    send(8'h0F);
    send(a);
    for (int i = 0; i < n; i++) begin
      send(seed + 8'(i * 7));
      exp_sp[(int'(a[4:0]) + i) % 32] = seed + 8'(i * 7);
    end
  endtask

  task automatic sp_check(input logic [7:0] a, input int n, input string req);
    line_reset();
    send(8'hAA);
    send(a);
    for (int i = 0; i < n; i++) take(exp_sp[(int'(a[4:0]) + i) % 32], req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tx_valid === 1'b0, "R1 tx_valid", int'(tx_valid), 0);
    chk(rx_ready === 1'b1, "R1 rx_ready", int'(rx_ready), 1);
    granted = 1'b1;
    sp_check(8'h00, 4, "R1 scratch zero");
    line_reset();
    send(8'hF0); send(8'h1C);
    for (int i = 0; i < 6; i++) take(exp_mem[(28 + i) % 32], "R1 memory zero");
  endtask

  task automatic t_basic();
    sp_write(8'h03, 5, 8'h41);
    sp_check(8'h03, 5, "R2 R3 R12 readback");
  endtask

  task automatic t_high_bits();
    sp_write(8'hE5, 2, 8'h9A);
    sp_check(8'h05, 2, "R4 low bits");
    sp_check(8'hE5, 1, "R4 read high");
  endtask

  task automatic t_wrap();
    sp_write(8'h1E, 4, 8'hC3);
    sp_check(8'h1E, 4, "R5 wrap");
  endtask

  task automatic t_long();
    for (int i = 0; i < 32; i++) exp_sp[i] = 8'(i * 13 + 1);
    line_reset();
    send(8'h0F); send(8'h00);
    for (int i = 0; i < 32; i++) send(exp_sp[i]);
    sp_check(8'h11, 70, "R6 endless stream");
  endtask

  task automatic t_hold();
    line_reset();
    send(8'hAA); send(8'h07);
    repeat (4) begin
      @(negedge clk);
      chk(tx_valid === 1'b1 && tx_data === exp_sp[7], "R8 stall hold", int'(tx_data), int'(exp_sp[7]));
    end
    take(exp_sp[7], "R8 first");
    take(exp_sp[8], "R8 advance once");
  endtask

  task automatic t_unknown();
    line_reset();
    send(8'h3C);
    send(8'h0F); send(8'h00); send(8'h77); send(8'h77);
    send(8'hAA); send(8'h00);
    @(negedge clk);
    chk(tx_valid === 1'b0, "R7 halted no tx", int'(tx_valid), 0);
    sp_check(8'h00, 3, "R7 no write");
  endtask

  task automatic t_reset_mid();
    line_reset();
    send(8'h0F); send(8'h0A);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'h5E; bus_reset = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; bus_reset = 1'b0;
    chk(tx_valid === 1'b0, "R6 reset idle", int'(tx_valid), 0);
    sp_check(8'h0A, 1, "R6 byte dropped");
  endtask

  task automatic t_grant();
    line_reset();
    granted = 1'b0;
    send(8'h0F); send(8'h00); send(8'hEE);
    granted = 1'b1;
    send(8'hAA); send(8'h02);
    take(exp_sp[2], "R11 ungranted ignored");
    sp_check(8'h00, 1, "R11 no write");
  endtask

  task automatic t_commit();
    line_reset();
    send(8'h55);
    for (int i = 0; i < 32; i++) exp_mem[i] = exp_sp[i];
    send(8'hF0); send(8'h00);
    @(negedge clk);
    chk(tx_valid === 1'b0, "R9 halt after commit", int'(tx_valid), 0);
    sp_write(8'h00, 8, 8'h10);
    line_reset();
    send(8'hF0); send(8'h1D);
    for (int i = 0; i < 36; i++) take(exp_mem[(29 + i) % 32], "R9 R10 memory read");
    sp_check(8'h00, 2, "R9 scratch kept");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin exp_sp[i] = 8'h00; exp_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_high_bits();
    t_wrap();
    t_long();
    t_hold();
    t_unknown();
    t_reset_mid();
    t_grant();
    t_commit();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule